// File: doc/BRIEF.md
# Power-Fail Access Gate Controller

This controller decides, cycle by cycle, whether the external byte-wide bus may reach the timekeeping registers and the RAM. It also decides which supply powers the core. It receives two digitized comparator flags. One says the main supply is above the power-fail level. The other says the supply is above the battery switch level. Both flags are synchronized before use.

The backup cell ships disconnected, in shelf mode. The first valid power-up connects it for good. After the supply comes back, access stays closed for a programmable recovery interval. A dip during that interval starts the interval again.

A mode input picks one of two switchover rules:
- **Higher-voltage rule:** the core goes to battery below the battery switch level.
- **Lower-voltage rule:** the core goes to battery only when the supply is below the lower of the two levels.

If power fails while a bus transaction is in progress, the controller aborts the transaction and masks the write strobe in the same cycle.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: Both comparator flags pass through two synchronizing flops. A flag change made between clock edges is seen by the control logic after the second following rising edge.
- R2: After a synchronous active-low reset, the following outputs are all 0: `access_en`, `bat_sel`, `bat_connected`, `xfer_abort` and `wr_strobe_out`.
- R3: `access_en` is 0 in every cycle in which the synchronized power-good flag is 0.
- R4: After the synchronized power-good flag rises, `access_en` becomes 1 exactly `REC_CYCLES`+1 rising edges later. This is `REC_CYCLES`+3 edges after the input change.
- R5: If the power-good flag drops during the recovery interval, the count is discarded. The full interval starts again when the flag returns.
- R6: `bat_connected` sets on the first edge at which the synchronized power-good flag is 1. It then stays 1 until the next reset, whatever the supply does.
- R7: While `bat_connected` is 0, `bat_sel` is 0 for any combination of flags.
- R8: With `mode_low_v`=0 (higher-voltage rule), `bat_sel` equals the inverse of the synchronized battery-level flag once the cell is connected.
- R9: With `mode_low_v`=1 (lower-voltage rule), `bat_sel` is 1 only when both synchronized flags are 0, once the cell is connected.
- R10: Suppose power-good is lost while access is open and `bus_req`=1. Then `xfer_abort` pulses for exactly one cycle, and in that same cycle `wr_strobe_out` is 0 even though `wr_strobe_in` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_ok_async | input | 1 | Comparator flag: supply above power-fail level (asynchronous) |
| bat_lvl_ok_async | input | 1 | Comparator flag: supply above battery switch level (asynchronous) |
| mode_low_v | input | 1 | 0 = higher-voltage switch rule, 1 = lower-of-two-levels rule |
| bus_req | input | 1 | A bus transaction is in progress |
| wr_strobe_in | input | 1 | Write strobe from the bus |
| access_en | output | 1 | Bus may access registers and RAM |
| wr_strobe_out | output | 1 | Write strobe gated by access |
| xfer_abort | output | 1 | One-cycle abort of an in-flight transaction |
| bat_sel | output | 1 | Core supplied from the backup cell |
| bat_connected | output | 1 | One-shot backup cell connect latch |

## Verification
The assertions check four things on every cycle:
- access is never open while synchronized power is low;
- the connect latch never falls;
- the battery select never rises before the latch is set;
- an abort is always followed by closed access, and recovery always falls back to off when power drops.

The bench scenarios are needed to show the exact recovery length, the restart after a brown-out, the two switchover rules and the two-flop input delay. Those depend on counted edges and on flag combinations chosen by the stimulus.

// File: rtl/pgc_pkg.sv
// Package: shared state encoding for the power-fail access gate.
package pgc_pkg;
    typedef enum logic [1:0] {
        PG_OFF     = 2'd0,   // supply below power-fail level, access closed
        PG_RECOVER = 2'd1,   // supply back, waiting out recovery interval
        PG_ON      = 2'd2    // access open
    } pg_state_t;
endpackage

// File: rtl/pgc_sync.sv
// Module: pgc_sync
// Two-flop synchronizer for a bundle of independent asynchronous flags.
// Assumes each bit is a slow level signal; no multi-bit coherency implied.
module pgc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic stg1, stg2;
            // Two-stage capture of one flag; resets to low (supply absent).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg1 <= 1'b0;
                    stg2 <= 1'b0;
                end else begin
                    stg1 <= d_async[gi];
                    stg2 <= stg1;
                end
            end
            assign q_sync[gi] = stg2;
        end
    endgenerate
endmodule

// File: rtl/pgc_recovery_fsm.sv
// Module: pgc_recovery_fsm
// Tracks OFF / RECOVER / ON. Opens access only after REC_CYCLES consecutive
// cycles of synchronized power-good; any dip returns to OFF and the count
// restarts. Assumes REC_CYCLES >= 2 and a synchronized pf_ok input.
module pgc_recovery_fsm
    import pgc_pkg::*;
#(
    parameter int REC_CYCLES = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok,
    output logic in_on,
    output logic on_loss
);
    localparam int CNT_W = $clog2(REC_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

    pg_state_t        st_q;
    logic [CNT_W-1:0] cnt_q;

    // State and recovery counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PG_OFF;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PG_OFF: begin
                    cnt_q <= '0;
                    if (pf_ok) st_q <= PG_RECOVER;
                end
                PG_RECOVER: begin
                    if (!pf_ok) begin
                        st_q  <= PG_OFF;
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        st_q <= PG_ON;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PG_ON: begin
                    if (!pf_ok) st_q <= PG_OFF;
                end
                default: st_q <= PG_OFF;
            endcase
        end
    end

    // Decode of the settled state and of the loss event.
    assign in_on   = (st_q == PG_ON);
    assign on_loss = (st_q == PG_ON) && !pf_ok;

    // R4
    // ON is only entered from a completed recovery count
    rec_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == PG_ON) |-> ($past(st_q) == PG_RECOVER && $past(cnt_q) == CNT_LAST));

    // R5
    // a dip during recovery always falls back to OFF
    rec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PG_RECOVER && !pf_ok) |=> (st_q == PG_OFF));
endmodule

// File: rtl/pgc_supply_select.sv
// Module: pgc_supply_select
// Holds the one-shot backup-cell connect latch and picks the core supply by
// the configured switchover rule. Assumes synchronized level flags.
module pgc_supply_select (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok,
    input  logic bat_lvl_ok,
    input  logic mode_low_v,
    output logic bat_sel,
    output logic bat_connected
);
    logic conn_q;
    logic below_rule;

    // One-shot latch: set on first power-good, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     conn_q <= 1'b0;
        else if (pf_ok) conn_q <= 1'b1;
    end

    // Switchover rule: high-voltage uses battery level only; low-voltage
    // waits until the supply is under both levels.
    always_comb begin
        if (mode_low_v) below_rule = !pf_ok && !bat_lvl_ok;
        else            below_rule = !bat_lvl_ok;
    end

    assign bat_sel       = conn_q && below_rule;
    assign bat_connected = conn_q;

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_q |=> conn_q);
endmodule

// File: rtl/pwr_gate_ctrl.sv
// Module: pwr_gate_ctrl (top)
// Gates bus access and selects the core supply from two comparator flags.
// Assumes comparator flags are asynchronous levels; rst_n is synchronous.
module pwr_gate_ctrl #(
    parameter int REC_CYCLES = 1147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok_async,
    input  logic bat_lvl_ok_async,
    input  logic mode_low_v,
    input  logic bus_req,
    input  logic wr_strobe_in,
    output logic access_en,
    output logic wr_strobe_out,
    output logic xfer_abort,
    output logic bat_sel,
    output logic bat_connected
);
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flags_sync;
    logic             pf_ok_s;
    logic             bat_lvl_s;
    logic             in_on;
    logic             on_loss;

    pgc_sync #(.W(NFLAG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bat_lvl_ok_async, pf_ok_async}),
        .q_sync  (flags_sync)
    );
    assign pf_ok_s   = flags_sync[0];
    assign bat_lvl_s = flags_sync[1];

    pgc_recovery_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_ok   (pf_ok_s),
        .in_on   (in_on),
        .on_loss (on_loss)
    );

    pgc_supply_select u_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .pf_ok         (pf_ok_s),
        .bat_lvl_ok    (bat_lvl_s),
        .mode_low_v    (mode_low_v),
        .bat_sel       (bat_sel),
        .bat_connected (bat_connected)
    );

    // Access gate closes in the very cycle power-good is lost.
    assign access_en     = in_on && pf_ok_s;
    assign wr_strobe_out = wr_strobe_in && access_en;
    assign xfer_abort    = on_loss && bus_req;

    // R3
    no_access_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_ok_s |-> !access_en);

    // R10
    abort_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> (!wr_strobe_out ##1 !access_en));

    // R7
    sel_needs_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> bat_connected);
endmodule

// File: tb/tb_pwr_gate_ctrl.sv
module tb_pwr_gate_ctrl;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf = 1'b0, bl = 1'b0, mode = 1'b0, req = 1'b0, wri = 1'b0;
    logic acc, wro, abt, bsel, bconn;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pwr_gate_ctrl #(.REC_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .pf_ok_async(pf), .bat_lvl_ok_async(bl),
        .mode_low_v(mode), .bus_req(req), .wr_strobe_in(wri),
        .access_en(acc), .wr_strobe_out(wro), .xfer_abort(abt),
        .bat_sel(bsel), .bat_connected(bconn));

    task automatic chk(input string req_tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req_tag, act, exp, $time);
        end
    endtask

    // advance n rising edges, then settle past the edge
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic p, input logic b);
        @(negedge clk);
        pf = p; bl = b;
    endtask

    task automatic t_reset;
        edges(3);
        chk("R2 access", acc, 1'b0);
        chk("R2 bat_sel", bsel, 1'b0);
        chk("R2 bat_connected", bconn, 1'b0);
        chk("R2 abort", abt, 1'b0);
        chk("R2 wr", wro, 1'b0);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic t_shelf;
        drive(1'b0, 1'b0);
        mode = 1'b0;
        edges(4);
        chk("R7 5V shelf sel", bsel, 1'b0);
        mode = 1'b1;
        edges(1);
        chk("R7 3V3 shelf sel", bsel, 1'b0);
        chk("R6 not yet connected", bconn, 1'b0);
    endtask

    task automatic t_first_powerup;
        mode = 1'b0;
        drive(1'b1, 1'b1);
        edges(1);
        chk("R1 one edge: not connected", bconn, 1'b0);
        edges(1);
        chk("R1 two edges: still closed", acc, 1'b0);
        edges(1);
        chk("R6 latch set", bconn, 1'b1);
        edges(N - 1);
        chk("R4 closed at N+2", acc, 1'b0);
        edges(1);
        chk("R4 open at N+3", acc, 1'b1);
        wri = 1'b1;
        #1 chk("R3 write passes when open", wro, 1'b1);
        wri = 1'b0;
    endtask

    task automatic t_brownout;
        drive(1'b0, 1'b1);
        edges(2);
        chk("R3 closed after loss", acc, 1'b0);
        drive(1'b1, 1'b1);
        edges(N / 2);
        drive(1'b0, 1'b1);
        edges(3);
        drive(1'b1, 1'b1);
        edges(N + 2);
        chk("R5 restart: closed at N+2", acc, 1'b0);
        edges(1);
        chk("R5 restart: open at N+3", acc, 1'b1);
    endtask

    task automatic t_abort;
        @(negedge clk);
        req = 1'b1; wri = 1'b1; pf = 1'b0;
        edges(1);
        chk("R10 no abort yet", abt, 1'b0);
        chk("R1 write still open", wro, 1'b1);
        edges(1);
        chk("R10 abort pulse", abt, 1'b1);
        chk("R10 write masked", wro, 1'b0);
        edges(1);
        chk("R10 abort one cycle", abt, 1'b0);
        chk("R3 closed", acc, 1'b0);
        req = 1'b0; wri = 1'b0;
        chk("R6 latch holds after loss", bconn, 1'b1);
    endtask

    task automatic t_modes;
        mode = 1'b0;
        drive(1'b1, 1'b0);
        edges(3);
        chk("R8 5V: above pf, below bat -> battery", bsel, 1'b1);
        drive(1'b0, 1'b1);
        edges(3);
        chk("R8 5V: above bat -> main", bsel, 1'b0);
        mode = 1'b1;
        drive(1'b1, 1'b0);
        edges(3);
        chk("R9 3V3: above pf -> main", bsel, 1'b0);
        drive(1'b0, 1'b1);
        edges(3);
        chk("R9 3V3: above bat -> main", bsel, 1'b0);
        drive(1'b0, 1'b0);
        edges(3);
        chk("R9 3V3: below both -> battery", bsel, 1'b1);
        mode = 1'b0;
        #1 chk("R8 5V: below both -> battery", bsel, 1'b1);
        edges(50);
        chk("R6 latch never clears", bconn, 1'b1);
    endtask

    initial begin
        t_reset;
        t_shelf;
        t_first_powerup;
        t_brownout;
        t_abort;
        t_modes;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule